// File: doc/BRIEF.md
# Fractional Slot Rate Throttle

This block meters the transmit slots granted to several stream channels that share one framed link. Each channel is programmed with a rate in slots per frame, made of a whole part and a 25-bit binary fraction. At every frame boundary the block gives each channel a whole-number slot allowance for the coming frame. Over many frames the allowances average to the programmed rate. The fraction is carried in a per-channel accumulator: each frame adds the fraction to it, and a carry out of the top bit grants one extra slot for that frame.

Software rounds the fraction up when it programs a rate, so the delivered average is never below the requested one. A rate write does not act at once. It is held in a shadow copy and a per-channel pending flag is raised. At the next frame boundary the shadow becomes the active rate and the accumulator restarts from zero, so a stream never sees a frame that mixes the old rate and the new one. The pending output tells software when every written rate has taken effect.

Top module: `rt_slot_throttle`

## Requirements
- R1: After reset every slot allowance is 0, `rate_pending` is 0, and every active rate, shadow rate and accumulator is 0.
- R2: When `wr_en` is high, the whole part `wr_int` and the fraction `wr_frac` go into the shadow rate of channel `wr_ch` (0 to NUM_CH-1). No allowance changes until the next `frame_start`.
- R3: On a `frame_start` clock edge, a channel with a pending rate makes its shadow rate active and restarts its accumulator from 0. In that same edge it computes the allowance from the new rate, so the first frame after the change adds the new fraction to zero.
- R4: `rate_pending` goes high in the cycle after a write and stays high until a `frame_start` edge with no write in the same cycle. It is low in the cycle after that edge.
- R5: At each `frame_start` edge a channel's allowance becomes X plus the carry out of the 25-bit sum of its accumulator and Y, and the lower 25 bits of that sum become the new accumulator. Over N frames the allowances add up to N*X plus the number of carries. For example, X=3 with Y=2^23 gives 26 slots in 8 frames.
- R6: Each allowance field changes only on a `frame_start` edge and holds its value in between.
- R7: The channels are independent. A write or a carry on one channel never changes another channel's allowance.
- R8: A write that falls in the same cycle as `frame_start` does not take effect in that frame. That frame applies the older pending shadow if one exists, the new value waits for the following frame, and `rate_pending` stays high.
- R9: Several writes to one channel before a `frame_start` keep only the last value.
- R10: The allowance is INT_W+1 bits wide. The largest whole part plus a carry (2^INT_W) comes out without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Rate write strobe |
| wr_ch | input | CH_W | Channel selected by the write |
| wr_int | input | INT_W | Whole slots per frame (X) |
| wr_frac | input | FRAC_W | Fraction of a slot per frame scaled by 2^25 (Y) |
| frame_start | input | 1 | One-cycle pulse that marks each frame boundary |
| slot_allow | output | NUM_CH*(INT_W+1) | Allowance per channel, channel c at bits [c*(INT_W+1) +: INT_W+1] |
| rate_pending | output | 1 | High while any written rate is not yet active |

## Verification
The directed cases cover the following patterns. A fraction of one half must make the allowance alternate between X and X+1, starting with X right after the change. A fraction of all ones must give X once and then X+1 on every later frame. A quarter fraction checked over eight frames shows that the accumulator keeps its remainder across frames rather than rounding each frame on its own. Writes in the same cycle as a frame boundary, back-to-back writes and the largest whole part test the ordering rules and the output width. A long random run with writes and frame pulses on all channels, checked cycle by cycle against a reference model in the bench, shows whether one channel's activity leaks into another.

// File: rtl/rt_pkg.sv
package rt_pkg;
   localparam int unsigned RT_NUM_CH_DEF = 4;
   localparam int unsigned RT_INT_W_DEF  = 6;
   localparam int unsigned RT_FRAC_W_DEF = 25;
endpackage

// File: rtl/rt_rate_shadow.sv
module rt_rate_shadow #(
   parameter int unsigned INT_W  = rt_pkg::RT_INT_W_DEF,
   parameter int unsigned FRAC_W = rt_pkg::RT_FRAC_W_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  logic [INT_W-1:0]  wr_int,
   input  logic [FRAC_W-1:0] wr_frac,
   input  logic              frame_start,
   output logic [INT_W-1:0]  sh_int,
   output logic [FRAC_W-1:0] sh_frac,
   output logic              pend
);
   // A write always wins over the frame boundary clearing the flag (R8).
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_int  <= '0;
         sh_frac <= '0;
         pend    <= 1'b0;
      end else if (wr_hit) begin
         sh_int  <= wr_int;
         sh_frac <= wr_frac;
         pend    <= 1'b1;
      end else if (frame_start) begin
         pend    <= 1'b0;
      end
   end
endmodule

// File: rtl/rt_frac_accum.sv
module rt_frac_accum #(
   parameter int unsigned INT_W  = rt_pkg::RT_INT_W_DEF,
   parameter int unsigned FRAC_W = rt_pkg::RT_FRAC_W_DEF,
   localparam int unsigned ALW_W = INT_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              apply,
   input  logic [INT_W-1:0]  new_int,
   input  logic [FRAC_W-1:0] new_frac,
   output logic [ALW_W-1:0]  allow
);
   logic [INT_W-1:0]  act_int;
   logic [FRAC_W-1:0] act_frac;
   logic [FRAC_W-1:0] acc;
   logic [INT_W-1:0]  eff_int;
   logic [FRAC_W-1:0] eff_frac;
   logic [FRAC_W-1:0] base;
   logic [FRAC_W:0]   sum;

   always_comb begin
      eff_int  = apply ? new_int  : act_int;
      eff_frac = apply ? new_frac : act_frac;
      base     = apply ? '0       : acc;
      sum      = {1'b0, base} + {1'b0, eff_frac};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_int  <= '0;
         act_frac <= '0;
         acc      <= '0;
         allow    <= '0;
      end else if (frame_start) begin
         if (apply) begin
            act_int  <= new_int;
            act_frac <= new_frac;
         end
         acc   <= sum[FRAC_W-1:0];
         allow <= ALW_W'(eff_int) + ALW_W'(sum[FRAC_W]);
      end
   end
endmodule

// File: rtl/rt_slot_throttle.sv
module rt_slot_throttle #(
   parameter int unsigned NUM_CH = rt_pkg::RT_NUM_CH_DEF,
   parameter int unsigned INT_W  = rt_pkg::RT_INT_W_DEF,
   parameter int unsigned FRAC_W = rt_pkg::RT_FRAC_W_DEF,
   localparam int unsigned CH_W  = $clog2(NUM_CH),
   localparam int unsigned ALW_W = INT_W + 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [CH_W-1:0]         wr_ch,
   input  logic [INT_W-1:0]        wr_int,
   input  logic [FRAC_W-1:0]       wr_frac,
   input  logic                    frame_start,
   output logic [NUM_CH*ALW_W-1:0] slot_allow,
   output logic                    rate_pending
);
   logic [NUM_CH-1:0] pend_vec;

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      logic              hit;
      logic [INT_W-1:0]  sh_int;
      logic [FRAC_W-1:0] sh_frac;

      assign hit = wr_en && (wr_ch == CH_W'(ch));

      rt_rate_shadow #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_shadow (
         .clk         (clk),
         .rst_n       (rst_n),
         .wr_hit      (hit),
         .wr_int      (wr_int),
         .wr_frac     (wr_frac),
         .frame_start (frame_start),
         .sh_int      (sh_int),
         .sh_frac     (sh_frac),
         .pend        (pend_vec[ch])
      );

      rt_frac_accum #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_accum (
         .clk         (clk),
         .rst_n       (rst_n),
         .frame_start (frame_start),
         .apply       (pend_vec[ch]),
         .new_int     (sh_int),
         .new_frac    (sh_frac),
         .allow       (slot_allow[ch*ALW_W +: ALW_W])
      );
   end

   assign rate_pending = |pend_vec;
endmodule

// File: rtl/rt_slot_throttle_chk.sv
module rt_slot_throttle_chk #(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned INT_W  = 6,
   parameter int unsigned FRAC_W = 25,
   localparam int unsigned ALW_W = INT_W + 1
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    wr_en,
   input logic                    frame_start,
   input logic [NUM_CH*ALW_W-1:0] slot_allow,
   input logic                    rate_pending
);
   initial begin
      assert (NUM_CH >= 2) else $error("NUM_CH must be at least 2");
      assert (INT_W >= 1 && FRAC_W >= 2) else $error("bad field widths");
   end

   assert_pend_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> rate_pending);

   assert_pend_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_pending && !frame_start) |=> rate_pending);

   assert_pend_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && !wr_en) |=> !rate_pending);

   assert_allow_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> $stable(slot_allow));
endmodule

bind rt_slot_throttle rt_slot_throttle_chk #(
   .NUM_CH(NUM_CH), .INT_W(INT_W), .FRAC_W(FRAC_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_en        (wr_en),
   .frame_start  (frame_start),
   .slot_allow   (slot_allow),
   .rate_pending (rate_pending)
);

// File: tb/tb_rt_slot_throttle.sv
`timescale 1ns/1ps
module tb_rt_slot_throttle;
   localparam int NCH = 4;
   localparam int IW  = 6;
   localparam int FW  = 25;
   localparam int AW  = IW + 1;
   localparam int CW  = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [CW-1:0] wr_ch = '0;
   logic [IW-1:0] wr_int = '0;
   logic [FW-1:0] wr_frac = '0;
   logic          frame_start = 1'b0;
   logic [NCH*AW-1:0] slot_allow;
   logic          rate_pending;

   int checks = 0;
   int fails  = 0;

   logic [IW-1:0] m_sh_i [NCH];
   logic [FW-1:0] m_sh_f [NCH];
   logic          m_pend [NCH];
   logic [IW-1:0] m_act_i [NCH];
   logic [FW-1:0] m_act_f [NCH];
   logic [FW-1:0] m_acc [NCH];
   logic [AW-1:0] m_allow [NCH];

   always #2 clk = ~clk;

   rt_slot_throttle #(.NUM_CH(NCH), .INT_W(IW), .FRAC_W(FW)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch),
      .wr_int(wr_int), .wr_frac(wr_frac), .frame_start(frame_start),
      .slot_allow(slot_allow), .rate_pending(rate_pending)
   );

   function automatic logic [AW-1:0] got_allow(int c);
      return slot_allow[c*AW +: AW];
   endfunction

   function automatic logic model_pending();
      logic p = 1'b0;
      for (int c = 0; c < NCH; c++) p |= m_pend[c];
      return p;
   endfunction

   task automatic model_reset();
      for (int c = 0; c < NCH; c++) begin
         m_sh_i[c] = '0; m_sh_f[c] = '0; m_pend[c] = 1'b0;
         m_act_i[c] = '0; m_act_f[c] = '0; m_acc[c] = '0; m_allow[c] = '0;
      end
   endtask

   task automatic model_edge(logic we, int ch, logic [IW-1:0] xi,
                             logic [FW-1:0] yf, logic fs);
      for (int c = 0; c < NCH; c++) begin
         if (fs) begin
            logic [IW-1:0] ei;
            logic [FW-1:0] ef;
            logic [FW-1:0] b;
            logic [FW:0]   s;
            ei = m_pend[c] ? m_sh_i[c] : m_act_i[c];
            ef = m_pend[c] ? m_sh_f[c] : m_act_f[c];
            b  = m_pend[c] ? '0 : m_acc[c];
            s  = {1'b0, b} + {1'b0, ef};
            m_allow[c] = AW'(ei) + AW'(s[FW]);
            m_acc[c] = s[FW-1:0];
            m_act_i[c] = ei;
            m_act_f[c] = ef;
         end
         if (we && ch == c) begin
            m_sh_i[c] = xi; m_sh_f[c] = yf; m_pend[c] = 1'b1;
         end else if (fs) begin
            m_pend[c] = 1'b0;
         end
      end
   endtask

   task automatic compare(string req);
      for (int c = 0; c < NCH; c++) begin
         checks++;
         if (got_allow(c) !== m_allow[c]) begin
            fails++;
            $display("FAIL %s ch%0d allowance got %0d expected %0d", req, c, got_allow(c), m_allow[c]);
         end
      end
      checks++;
      if (rate_pending !== model_pending()) begin
         fails++;
         $display("FAIL %s pending got %0b expected %0b", req, rate_pending, model_pending());
      end
   endtask

   task automatic step(string req, logic we, int ch, int xi, int yf, logic fs);
      wr_en = we; wr_ch = CW'(ch); wr_int = IW'(xi); wr_frac = FW'(yf);
      frame_start = fs;
      @(posedge clk);
      model_edge(we, ch, IW'(xi), FW'(yf), fs);
      @(negedge clk);
      wr_en = 1'b0; frame_start = 1'b0;
      compare(req);
   endtask

   task automatic expect_val(string req, int got, int exp);
      checks++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s got %0d expected %0d", req, got, exp);
      end
   endtask

   initial begin
      #(4 * 190000);
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      int total;
      void'($urandom(32'd20240611));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1");
      expect_val("R1 allow0", int'(got_allow(0)), 0);

      // R2: write holds off until frame boundary
      step("R2", 1'b1, 0, 5, 1 << 24, 1'b0);
      expect_val("R2 allow unchanged", int'(got_allow(0)), 0);
      expect_val("R4 pending set", int'(rate_pending), 1);
      step("R2", 1'b0, 0, 0, 0, 1'b0);
      // R3: apply with accumulator from zero -> X
      step("R3", 1'b0, 0, 0, 0, 1'b1);
      expect_val("R3 first frame", int'(got_allow(0)), 5);
      expect_val("R4 pending clear", int'(rate_pending), 0);
      step("R5", 1'b0, 0, 0, 0, 1'b1);
      expect_val("R5 carry frame", int'(got_allow(0)), 6);
      step("R5", 1'b0, 0, 0, 0, 1'b1);
      expect_val("R5 no carry frame", int'(got_allow(0)), 5);
      repeat (4) step("R6", 1'b0, 0, 0, 0, 1'b0);
      expect_val("R6 hold", int'(got_allow(0)), 5);

      // R9: last write wins
      step("R9", 1'b1, 1, 2, 0, 1'b0);
      step("R9", 1'b1, 1, 7, 0, 1'b0);
      step("R9", 1'b0, 0, 0, 0, 1'b1);
      expect_val("R9 last write", int'(got_allow(1)), 7);

      // R8: write coinciding with frame boundary waits
      step("R8", 1'b1, 2, 1, 0, 1'b0);
      step("R8", 1'b1, 2, 4, 0, 1'b1);
      expect_val("R8 older shadow applied", int'(got_allow(2)), 1);
      expect_val("R8 pending kept", int'(rate_pending), 1);
      step("R8", 1'b0, 0, 0, 0, 1'b1);
      expect_val("R8 newer applied", int'(got_allow(2)), 4);

      // R10: largest whole part with carry
      step("R10", 1'b1, 3, 63, (1 << 25) - 1, 1'b0);
      step("R10", 1'b0, 0, 0, 0, 1'b1);
      expect_val("R10 first", int'(got_allow(3)), 63);
      step("R10", 1'b0, 0, 0, 0, 1'b1);
      expect_val("R10 max", int'(got_allow(3)), 64);

      // R5 long-run average: X=3, Y=2^23 over 8 frames -> 26
      step("R5", 1'b1, 0, 3, 1 << 23, 1'b0);
      total = 0;
      for (int f = 0; f < 8; f++) begin
         step("R5", 1'b0, 0, 0, 0, 1'b1);
         total += int'(got_allow(0));
      end
      expect_val("R5 eight frame sum", total, 26);

      // R7: random traffic on all channels
      for (int i = 0; i < 3000; i++) begin
         logic we, fs;
         int ch, xi, yf;
         we = ($urandom % 3) == 0;
         fs = ($urandom % 4) == 0;
         ch = int'($urandom % NCH);
         xi = int'($urandom % 64);
         case ($urandom % 4)
            0: yf = 0;
            1: yf = (1 << 25) - 1;
            default: yf = int'($urandom % (1 << 25));
         endcase
         step("R7", we, ch, xi, yf, fs);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule